// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block produces the digital drive waveforms for a two-phase linear CCD image sensor. It makes the shift-gate pulse that dumps every photodiode's charge into the analog transfer register, the complementary transfer clock pair that walks that charge to the output node, and a per-pixel reset pulse that clears the output node before each new charge packet arrives. Every drive output comes from a flop, so the sensor pins see no decode glitches.

A line readout starts on a `start` pulse, or on its own when a nonzero integration period is programmed. In that case the gate pulses repeat at that period, which is the sensor's integration time. During readout the block follows the sensor's fixed output order. It raises one region flag per pixel slot (blank feed, black reference, invalid, valid, overrun) for a downstream sampler, and it gives a running index over the valid pixels. No data moves through the block: every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `ccd_tg`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sg`=0, `phir`=0, `phi1`=1, `phi2`=0, `line_busy`=0, every region flag is 0 and `pix_idx`=0.
- R2: `start` launches a line only when the block is idle and `en` is high. A `start` during a line in progress has no effect and leaves no pending launch.
- R3: After a launch, `sg` stays low for GATE_SETUP+1 cycles (default 3), then is high for GATE_WIDTH cycles (default 4), then low for GATE_HOLD cycles (default 2) before readout. `phi1`=1 and `phi2`=0 from launch to the end of the hold.
- R4: Readout is 2*N_PERIODS slots (default 2230) of SLOT_CLKS clocks (default 4). `phir` is high on the first clock of each slot only.
- R5: `phi2` is always the inverse of `phi1`. In readout, `phi1` falls on clock SLOT_CLKS/2 of even slots (slot 0 is even) and rises on that clock of odd slots. That gives N_PERIODS full periods (default 1115) per line, and `phi1` never changes while `phir` is high.
- R6: Exactly one region flag is high in each readout slot, in slot order: `reg_blank` for slots 0..7, `reg_black` 8..59, `reg_invalid` 60..62, `reg_valid` 63..2222, `reg_invalid` 2223..2225. Outside readout all flags are 0.
- R7: `reg_valid` is high for exactly 2160 consecutive slots, and `pix_idx` counts 0 to 2159 across them, one step per slot. `pix_idx` is 0 outside valid slots.
- R8: The slots after the trailing invalid pixels (2226..2229 by default) raise `reg_overrun` and not `reg_valid`.
- R9: With `int_period` nonzero and `en` high, `sg` rises exactly every `int_period` clocks once the period is at least the minimum line period (default 8929 clocks). With `int_period`=0 only `start` launches lines.
- R10: A nonzero `int_period` below the minimum line period gives a gate-to-gate interval equal to that minimum, and `int_clamped` reads 1. Otherwise `int_clamped` reads 0.
- R11: With `en` low no line launches, from `start` or from the integration timer. A line already running when `en` falls completes with its full waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows new lines to launch |
| start | input | 1 | Single-cycle request to launch a line |
| int_period | input | INT_W | Gate-to-gate period in clocks; 0 turns the timer off |
| sg | output | 1 | Shift-gate pulse |
| phi1 | output | 1 | Transfer clock, phase 1 |
| phi2 | output | 1 | Transfer clock, phase 2 |
| phir | output | 1 | Output-node reset pulse |
| line_busy | output | 1 | A line sequence is in progress |
| reg_blank | output | 1 | Slot is a blank-feed pixel |
| reg_black | output | 1 | Slot is a black-reference pixel |
| reg_invalid | output | 1 | Slot is an invalid pixel |
| reg_valid | output | 1 | Slot is a valid image pixel |
| reg_overrun | output | 1 | Slot lies past the last sensor pixel |
| pix_idx | output | IDX_W | Index of the current valid pixel |
| int_clamped | output | 1 | The programmed period was raised to the minimum |

## Verification
The bench walks complete lines clock by clock. It catches a slot decode that is off by one at any of the five region boundaries: such a design shifts a flag edge, so the valid run is not 2160 long or the index does not end at 2159. It counts falling `phi1` edges against 1115 and checks each edge's position inside the slot. A transfer phase placed on the reset clock, or a missing last period, shows up there. It measures gate-to-gate intervals just above the minimum and far below it. A clamp compared off by one, or a timer restarted at the wrong point, moves that interval by a cycle. It also pulses `start` mid-line and with `en` low, which catches a design that latches such a request and fires a stray gate later.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_HOLD,
    ST_READ
  } tg_state_t;

  typedef struct packed {
    logic blank;
    logic black;
    logic invalid;
    logic valid;
    logic overrun;
  } tg_region_t;

endpackage

// File: rtl/ccd_tg_integ.sv
module ccd_tg_integ #(
  parameter int INT_W      = 24,
  parameter int MIN_PERIOD = 8929
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] int_period,
  input  logic             launch,
  output logic             trigger,
  output logic             clamped
);

  localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_PERIOD);

  logic [INT_W-1:0] cnt;
  logic [INT_W-1:0] eff;
  logic             auto_on;

  assign auto_on = (int_period != '0);
  assign eff     = (int_period < MIN_V) ? MIN_V : int_period;
  assign trigger = auto_on && (cnt >= eff);

  // cnt equals the number of clocks since the last launch, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clamped <= 1'b0;
    end else begin
      if (launch)
        cnt <= INT_W'(1);
      else if (cnt != '1)
        cnt <= cnt + 1'b1;
      clamped <= auto_on && (int_period < MIN_V);
    end
  end

  // R10: no timer launch before the minimum line period has elapsed
  p_floor_r10: assert property (@(posedge clk) disable iff (rst)
    (launch && trigger) |-> (cnt >= MIN_V));

endmodule

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int GATE_SETUP = 2,
  parameter int GATE_WIDTH = 4,
  parameter int GATE_HOLD  = 2,
  parameter int SLOT_CLKS  = 4,
  parameter int N_SLOTS    = 2230,
  parameter int SUB_W      = 2,
  parameter int SLOT_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output tg_state_t         st,
  output logic [SUB_W-1:0]  sub,
  output logic [SLOT_W-1:0] slot,
  output logic              launch
);

  localparam int PC_MAX = (GATE_SETUP > GATE_WIDTH)
                        ? ((GATE_SETUP > GATE_HOLD) ? GATE_SETUP : GATE_HOLD)
                        : ((GATE_WIDTH > GATE_HOLD) ? GATE_WIDTH : GATE_HOLD);
  localparam int PC_W   = $clog2(PC_MAX + 1);

  logic [PC_W-1:0] pcnt;

  assign launch = (st == ST_IDLE) && go;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      pcnt <= '0;
      sub  <= '0;
      slot <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            st   <= ST_SETUP;
            pcnt <= '0;
          end
        end
        ST_SETUP: begin
          if (pcnt == PC_W'(GATE_SETUP - 1)) begin
            st   <= ST_GATE;
            pcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_GATE: begin
          if (pcnt == PC_W'(GATE_WIDTH - 1)) begin
            st   <= ST_HOLD;
            pcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pcnt == PC_W'(GATE_HOLD - 1)) begin
            st   <= ST_READ;
            pcnt <= '0;
            sub  <= '0;
            slot <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_READ: begin
          if (sub == SUB_W'(SLOT_CLKS - 1)) begin
            sub <= '0;
            if (slot == SLOT_W'(N_SLOTS - 1))
              st <= ST_IDLE;
            else
              slot <= slot + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the gate is entered only from setup, readout only from hold
  p_gate_order_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GATE && $past(st) != ST_GATE) |-> $past(st) == ST_SETUP);
  p_read_order_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ && $past(st) != ST_READ) |-> $past(st) == ST_HOLD);

endmodule

// File: rtl/ccd_tg_drive.sv
module ccd_tg_drive
  import ccd_tg_pkg::*;
#(
  parameter int SLOT_CLKS  = 4,
  parameter int SUB_W      = 2,
  parameter int SLOT_W     = 12,
  parameter int N_BLANK    = 8,
  parameter int N_BLACK    = 52,
  parameter int N_LEAD_INV = 3,
  parameter int N_VALID    = 2160,
  parameter int N_TAIL_INV = 3,
  parameter int IDX_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  tg_state_t         st,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SLOT_W-1:0] slot,
  output logic              sg,
  output logic              phi1,
  output logic              phi2,
  output logic              phir,
  output logic              busy,
  output tg_region_t        rg,
  output logic [IDX_W-1:0]  pix_idx
);

  localparam int HALF     = SLOT_CLKS / 2;
  localparam int BLACK_LO = N_BLANK;
  localparam int INV1_LO  = BLACK_LO + N_BLACK;
  localparam int VALID_LO = INV1_LO + N_LEAD_INV;
  localparam int INV2_LO  = VALID_LO + N_VALID;
  localparam int OVR_LO   = INV2_LO + N_TAIL_INV;

  logic              in_read;
  logic              n_sg, n_phi1, n_phir, n_busy;
  tg_region_t        n_rg;
  logic [SLOT_W-1:0] rel;
  logic [IDX_W-1:0]  n_idx;

  always_comb begin
    in_read = (st == ST_READ);
    n_sg    = (st == ST_GATE);
    n_busy  = (st != ST_IDLE);
    n_phir  = in_read && (sub == '0);
    // phi1 parks high outside readout; in readout it toggles at mid-slot
    if (!in_read)
      n_phi1 = 1'b1;
    else if (slot[0])
      n_phi1 = (sub >= SUB_W'(HALF));
    else
      n_phi1 = (sub < SUB_W'(HALF));

    n_rg.blank   = in_read && (slot < SLOT_W'(BLACK_LO));
    n_rg.black   = in_read && (slot >= SLOT_W'(BLACK_LO)) && (slot < SLOT_W'(INV1_LO));
    n_rg.invalid = in_read && (((slot >= SLOT_W'(INV1_LO)) && (slot < SLOT_W'(VALID_LO))) ||
                               ((slot >= SLOT_W'(INV2_LO)) && (slot < SLOT_W'(OVR_LO))));
    n_rg.valid   = in_read && (slot >= SLOT_W'(VALID_LO)) && (slot < SLOT_W'(INV2_LO));
    n_rg.overrun = in_read && (slot >= SLOT_W'(OVR_LO));

    rel   = slot - SLOT_W'(VALID_LO);
    n_idx = n_rg.valid ? IDX_W'(rel) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sg      <= 1'b0;
      phi1    <= 1'b1;
      phi2    <= 1'b0;
      phir    <= 1'b0;
      busy    <= 1'b0;
      rg      <= '0;
      pix_idx <= '0;
    end else begin
      sg      <= n_sg;
      phi1    <= n_phi1;
      phi2    <= ~n_phi1;
      phir    <= n_phir;
      busy    <= n_busy;
      rg      <= n_rg;
      pix_idx <= n_idx;
    end
  end

  // R3: transfer pair parked during the gate pulse
  p_sg_park_r3: assert property (@(posedge clk) disable iff (rst)
    sg |-> (phi1 && !phi2));
  // R5: no transfer edge on a reset clock
  p_phir_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    phir |-> $stable(phi1));
  // R6: at most one region flag at a time
  p_region_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rg));
  // R6: valid run is entered only from the leading invalid run
  p_valid_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rg.valid) |-> $past(rg.invalid));
  // R7: index starts at zero and advances by one
  p_idx_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rg.valid) |-> (pix_idx == '0));
  p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
    (rg.valid && $past(rg.valid) && (pix_idx != $past(pix_idx)))
      |-> (pix_idx == $past(pix_idx) + 1'b1));

endmodule

// File: rtl/ccd_tg.sv
module ccd_tg
  import ccd_tg_pkg::*;
#(
  parameter int GATE_SETUP = 2,
  parameter int GATE_WIDTH = 4,
  parameter int GATE_HOLD  = 2,
  parameter int SLOT_CLKS  = 4,
  parameter int N_PERIODS  = 1115,
  parameter int N_BLANK    = 8,
  parameter int N_BLACK    = 52,
  parameter int N_LEAD_INV = 3,
  parameter int N_VALID    = 2160,
  parameter int N_TAIL_INV = 3,
  parameter int IDX_W      = 12,
  parameter int INT_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [INT_W-1:0] int_period,
  output logic             sg,
  output logic             phi1,
  output logic             phi2,
  output logic             phir,
  output logic             line_busy,
  output logic             reg_blank,
  output logic             reg_black,
  output logic             reg_invalid,
  output logic             reg_valid,
  output logic             reg_overrun,
  output logic [IDX_W-1:0] pix_idx,
  output logic             int_clamped
);

  localparam int N_SLOTS    = 2 * N_PERIODS;
  localparam int SLOT_W     = $clog2(N_SLOTS);
  localparam int SUB_W      = $clog2(SLOT_CLKS);
  localparam int LINE_CLKS  = GATE_SETUP + GATE_WIDTH + GATE_HOLD + N_SLOTS * SLOT_CLKS;
  localparam int MIN_PERIOD = LINE_CLKS + 1;

  tg_state_t         st;
  logic [SUB_W-1:0]  sub;
  logic [SLOT_W-1:0] slot;
  logic              launch, trigger, go;
  tg_region_t        rg;

  assign go = en && (start || trigger);

  ccd_tg_integ #(
    .INT_W      (INT_W),
    .MIN_PERIOD (MIN_PERIOD)
  ) u_integ (
    .clk        (clk),
    .rst        (rst),
    .int_period (int_period),
    .launch     (launch),
    .trigger    (trigger),
    .clamped    (int_clamped)
  );

  ccd_tg_seq #(
    .GATE_SETUP (GATE_SETUP),
    .GATE_WIDTH (GATE_WIDTH),
    .GATE_HOLD  (GATE_HOLD),
    .SLOT_CLKS  (SLOT_CLKS),
    .N_SLOTS    (N_SLOTS),
    .SUB_W      (SUB_W),
    .SLOT_W     (SLOT_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .st     (st),
    .sub    (sub),
    .slot   (slot),
    .launch (launch)
  );

  ccd_tg_drive #(
    .SLOT_CLKS  (SLOT_CLKS),
    .SUB_W      (SUB_W),
    .SLOT_W     (SLOT_W),
    .N_BLANK    (N_BLANK),
    .N_BLACK    (N_BLACK),
    .N_LEAD_INV (N_LEAD_INV),
    .N_VALID    (N_VALID),
    .N_TAIL_INV (N_TAIL_INV),
    .IDX_W      (IDX_W)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .sub     (sub),
    .slot    (slot),
    .sg      (sg),
    .phi1    (phi1),
    .phi2    (phi2),
    .phir    (phir),
    .busy    (line_busy),
    .rg      (rg),
    .pix_idx (pix_idx)
  );

  assign reg_blank   = rg.blank;
  assign reg_black   = rg.black;
  assign reg_invalid = rg.invalid;
  assign reg_valid   = rg.valid;
  assign reg_overrun = rg.overrun;

  // R1: the cycle after reset shows the idle drive levels
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sg && phi1 && !phi2 && !phir && !line_busy && !reg_valid));
  // R11: with en low the idle block does not start a line
  p_en_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!en && !line_busy && !$past(line_busy)) |=> !sg);

endmodule

// File: tb/ccd_tg_bench.sv
module ccd_tg_bench;

  localparam int SETUP   = 2;
  localparam int WIDTH   = 4;
  localparam int HOLD    = 2;
  localparam int SLOTCK  = 4;
  localparam int NSLOT   = 2230;
  localparam int NPER    = 1115;
  localparam int MINPER  = 8929;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        start = 1'b0;
  logic [23:0] int_period = '0;
  logic        sg, phi1, phi2, phir, line_busy;
  logic        reg_blank, reg_black, reg_invalid, reg_valid, reg_overrun;
  logic [11:0] pix_idx;
  logic        int_clamped;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ccd_tg u_ccd_tg (
    .clk(clk), .rst(rst), .en(en), .start(start), .int_period(int_period),
    .sg(sg), .phi1(phi1), .phi2(phi2), .phir(phir), .line_busy(line_busy),
    .reg_blank(reg_blank), .reg_black(reg_black), .reg_invalid(reg_invalid),
    .reg_valid(reg_valid), .reg_overrun(reg_overrun), .pix_idx(pix_idx),
    .int_clamped(int_clamped)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_rise(input int limit, output bit seen, output int cyc);
    logic prev;
    seen = 1'b0;
    cyc  = 0;
    prev = sg;
    while (!seen && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (sg && !prev) seen = 1'b1;
      prev = sg;
    end
  endtask

  // entered at the negedge where sg is first seen high
  task automatic walk_line();
    int e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, e8 = 0;
    int falls = 0, vcount = 0, last_idx = -1;
    logic prev_phi1;
    for (int i = 0; i < WIDTH; i++) begin
      if (i > 0) @(negedge clk);
      if (!(sg && phi1 && !phi2)) e3++;
    end
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      if (!(!sg && phi1 && !phi2 && !phir)) e3++;
    end
    prev_phi1 = phi1;
    for (int k = 0; k < NSLOT; k++) begin
      for (int s = 0; s < SLOTCK; s++) begin
        logic ep1;
        logic [4:0] ef;
        @(negedge clk);
        ep1 = (k % 2 == 1) ? (s >= SLOTCK/2) : (s < SLOTCK/2);
        if (phir !== (s == 0)) e4++;
        if (phi1 !== ep1 || phi2 !== !ep1) e5++;
        if (phir && phi1 !== prev_phi1) e5++;
        if (prev_phi1 && !phi1) falls++;
        prev_phi1 = phi1;
        ef = {k < 8, k >= 8 && k < 60,
              (k >= 60 && k < 63) || (k >= 2223 && k < 2226),
              k >= 63 && k < 2223, k >= 2226};
        if ({reg_blank, reg_black, reg_invalid, reg_valid, reg_overrun} !== ef) e6++;
        if (k >= 2226 && (reg_valid || !reg_overrun)) e8++;
        if (reg_valid) begin
          if (s == 0) vcount++;
          if (pix_idx !== 12'(k - 63)) e7++;
          last_idx = int'(pix_idx);
        end else if (pix_idx !== 12'd0) e7++;
      end
    end
    @(negedge clk);
    if ({reg_blank, reg_black, reg_invalid, reg_valid, reg_overrun, phir} !== 6'b0) e6++;
    check(e3 == 0, "R3 gate/hold waveform mismatches", e3, 0);
    check(e4 == 0, "R4 phir slot mismatches", e4, 0);
    check(e5 == 0, "R5 transfer clock mismatches", e5, 0);
    check(falls == NPER, "R5 phi1 falling edges per line", falls, NPER);
    check(e6 == 0, "R6 region flag mismatches", e6, 0);
    check(vcount == 2160, "R7 valid slot count", vcount, 2160);
    check(e7 == 0 && last_idx == 2159, "R7 index last value", last_idx, 2159);
    check(e8 == 0, "R8 overrun slot mismatches", e8, 0);
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    rises = 0;
    prev = sg;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sg && !prev) rises++;
      prev = sg;
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    check(!sg && !phir && !line_busy, "R1 sg/phir/busy in reset", {sg, phir, line_busy}, 0);
    check(phi1 && !phi2, "R1 transfer pair parked in reset", {phi1, phi2}, 2);
    check({reg_blank, reg_black, reg_invalid, reg_valid, reg_overrun} == 0 && pix_idx == 0,
          "R1 flags and index in reset", pix_idx, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!sg && phi1 && !phi2 && !line_busy, "R1 idle after reset release",
          {sg, phi1, phi2, line_busy}, 4);
  endtask

  task automatic test_single_line();
    int n = 0;
    int bad = 0;
    en = 1'b1;
    pulse_start();
    while (!sg && n < 50) begin
      if (!(phi1 && !phi2)) bad++;
      @(negedge clk);
      n++;
    end
    check(n == SETUP + 1, "R3 launch to gate delay", n, SETUP + 1);
    check(bad == 0, "R3 phi parked during setup", bad, 0);
    walk_line();
  endtask

  task automatic test_start_ignored();
    bit seen;
    int cyc, rises, w;
    pulse_start();
    wait_rise(50, seen, cyc);
    check(seen, "R2 start launches line", seen, 1);
    repeat (1000) @(negedge clk);
    check(line_busy, "R2 line in progress", line_busy, 1);
    pulse_start();
    w = 0;
    while (line_busy && w < 20000) begin
      @(negedge clk);
      w++;
    end
    count_rises(500, rises);
    check(rises == 0, "R2 start during line ignored", rises, 0);
  endtask

  task automatic test_enable_low();
    bit seen;
    int cyc, rises;
    en = 1'b0;
    pulse_start();
    count_rises(300, rises);
    check(rises == 0 && !line_busy, "R11 start with en low ignored", rises, 0);
    en = 1'b1;
    pulse_start();
    wait_rise(50, seen, cyc);
    en = 1'b0;
    int_period = 24'd100;
    walk_line();
    count_rises(300, rises);
    check(rises == 0, "R11 no timer launch with en low", rises, 0);
    int_period = '0;
  endtask

  task automatic test_integration();
    bit seen;
    int cyc;
    int_period = 24'd10000;
    en = 1'b1;
    wait_rise(30000, seen, cyc);
    check(seen, "R9 timer launches line", seen, 1);
    for (int r = 0; r < 2; r++) begin
      wait_rise(30000, seen, cyc);
      check(seen && cyc == 10000, "R9 gate-to-gate interval", cyc, 10000);
    end
    check(!int_clamped, "R10 no clamp above minimum", int_clamped, 0);
  endtask

  task automatic test_clamp();
    bit seen;
    int cyc;
    int_period = 24'd100;
    wait_rise(30000, seen, cyc);
    wait_rise(30000, seen, cyc);
    check(seen && cyc == MINPER, "R10 clamped interval", cyc, MINPER);
    check(int_clamped, "R10 clamp status", int_clamped, 1);
    int_period = '0;
    en = 1'b0;
    repeat (20) @(negedge clk);
    check(!int_clamped, "R10 clamp clears when timer off", int_clamped, 0);
  endtask

  initial begin
    test_reset();
    test_single_line();
    test_start_ignored();
    test_enable_low();
    test_integration();
    test_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule